// File: doc/BRIEF.md
# Indexed Configuration Register Slave on I2C

This block is a two-wire serial slave that gives a host byte-wide access to a small bank of power-configuration and identification registers. The seven-bit device address is fixed in its upper six bits, and the lowest bit follows a board strap, so two devices can share one bus. After the address, the host sends a command byte. Its top bit flags a single-byte operation and its low seven bits pick the register.

A write is one transaction: address with write, command, data, Stop. A read sets the offset with a write phase, then issues a repeated Start and the address with read, and the slave returns one byte. One bit of the memory-rail register tracks a live detect pin instead of stored data. The register contents are exported on parallel outputs to the power sequencing logic. Both bus lines pass through a two-flop synchroniser on the system clock, and the slave drives SDA only through an output-enable that pulls the line low.

Top module: `i2c_cfg_regs`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {010111, strap_a0}, so the byte is 5Ch with the strap low and 5Eh with it high, plus the R/W bit in bit 0. After a mismatch it never pulls SDA low until the next Start.
- R2: A byte write (Start, address+W, command, data, Stop) whose command has bit 7 set stores the data byte at the offset in command bits [6:0]. All three bytes are acknowledged, and the target output changes while SCL is low.
- R3: A byte read (write phase with command, repeated Start, address+R) returns the register at the offset most significant bit first. SDA changes only while SCL is low, and the slave releases SDA after the eighth bit.
- R4: A command byte with bit 7 clear is not acknowledged. The following data byte is not acknowledged either, and no register changes.
- R5: After reset, offsets 00h, 01h and 03h hold 00h and offset 05h holds 07h.
- R6: Offset 04h always reads A1h and offset 06h always reads 00h. Writes to them have no effect.
- R7: Bit 7 of offset 02h always equals the type_det pin and cannot be written. Bits [6:4] read 0 and bits [3:0] are writable.
- R8: Only bits [2:0] of offset 01h are stored. Bits [7:3] always read 0.
- R9: Offsets other than 00h–06h read 00h, and writes to them change no register.
- R10: cfg_usb, cfg_pci, cfg_mem, cfg_lr and cfg_uv show the readable contents of offsets 00h, 01h, 02h, 03h and 05h at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, pull SDA low |
| strap_a0 | input | 1 | Board strap giving address bit 0 |
| type_det | input | 1 | Live memory-type detect pin |
| cfg_usb | output | 8 | Contents of offset 00h |
| cfg_pci | output | 8 | Contents of offset 01h |
| cfg_mem | output | 8 | Contents of offset 02h |
| cfg_lr | output | 8 | Contents of offset 03h |
| cfg_uv | output | 8 | Contents of offset 05h |

## Verification
The assertions assume the master changes SDA only while SCL is low, except for its own Start and Stop conditions. They also assume SCL stays at each level for many system clocks, so that a synchronised edge is seen well before the next bus edge. The bench's master holds each bus phase for ten system clocks and moves SDA only in the middle of the SCL low phase. It never issues a Stop while the slave is driving. Under those conditions the slave's SDA enable and the exported registers change only while SCL is low.

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
  parameter logic [5:0] ADDR_HI = 6'b010111,
  parameter logic [7:0] CHIP_ID = 8'hA1,
  parameter logic [7:0] VER_ID  = 8'h00,
  parameter logic [7:0] UV_RST  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a0,
  input  logic       type_det,
  output logic [7:0] cfg_usb,
  output logic [7:0] cfg_pci,
  output logic [7:0] cfg_mem,
  output logic [7:0] cfg_lr,
  output logic [7:0] cfg_uv
);
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_DACK, S_RDAT, S_SKIP
  } st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] shreg, tx, rd_data;
  logic [6:0] ptr;
  logic [3:0] bitcnt;
  logic       rw;
  logic [7:0] r_usb, r_lr, r_uv;
  logic [2:0] r_pci;
  logic [3:0] r_mem;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl      = scl_q[1];
  wire sda      = sda_q[1];
  wire scl_rise = scl & ~scl_q[2];
  wire scl_fall = ~scl & scl_q[2];
  wire start_c  = scl & scl_q[2] & sda_q[2] & ~sda;
  wire stop_c   = scl & scl_q[2] & ~sda_q[2] & sda;

  assign cfg_usb = r_usb;
  assign cfg_pci = {5'b0, r_pci};
  assign cfg_mem = {type_det, 3'b0, r_mem};
  assign cfg_lr  = r_lr;
  assign cfg_uv  = r_uv;

  always_comb
    case (ptr)
      7'h00:   rd_data = cfg_usb;
      7'h01:   rd_data = cfg_pci;
      7'h02:   rd_data = cfg_mem;
      7'h03:   rd_data = cfg_lr;
      7'h04:   rd_data = CHIP_ID;
      7'h05:   rd_data = cfg_uv;
      7'h06:   rd_data = VER_ID;
      default: rd_data = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      shreg  <= '0;
      tx     <= '0;
      ptr    <= '0;
      bitcnt <= '0;
      rw     <= 1'b0;
      r_usb  <= '0;
      r_pci  <= '0;
      r_mem  <= '0;
      r_lr   <= '0;
      r_uv   <= UV_RST;
    end else if (start_c) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        S_ADDR, S_CMD, S_WDAT: begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        S_RDAT:  bitcnt <= bitcnt + 4'd1;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_ADDR: if (bitcnt == 4'd8) begin
          if (shreg[7:1] == {ADDR_HI, strap_a0}) begin
            rw     <= shreg[0];
            sda_oe <= 1'b1;
            st     <= S_AACK;
          end else st <= S_SKIP;
        end
        S_AACK: begin
          bitcnt <= '0;
          if (rw) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            st     <= S_RDAT;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_CMD;
          end
        end
        S_CMD: if (bitcnt == 4'd8) begin
          if (shreg[7]) begin
            ptr    <= shreg[6:0];
            sda_oe <= 1'b1;
            st     <= S_CACK;
          end else st <= S_SKIP;
        end
        S_CACK: begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          st     <= S_WDAT;
        end
        S_WDAT: if (bitcnt == 4'd8) begin
          sda_oe <= 1'b1;
          st     <= S_DACK;
          case (ptr)
            7'h00:   r_usb <= shreg;
            7'h01:   r_pci <= shreg[2:0];
            7'h02:   r_mem <= shreg[3:0];
            7'h03:   r_lr  <= shreg;
            7'h05:   r_uv  <= shreg;
            default: ;
          endcase
        end
        S_DACK: begin
          sda_oe <= 1'b0;
          st     <= S_SKIP;
        end
        S_RDAT: if (bitcnt == 4'd8) begin
          sda_oe <= 1'b0;
          st     <= S_SKIP;
        end else begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/i2c_cfg_regs_chk.sv
module i2c_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       type_det,
  input logic [7:0] cfg_usb,
  input logic [7:0] cfg_pci,
  input logic [7:0] cfg_mem,
  input logic [7:0] cfg_lr,
  input logic [7:0] cfg_uv
);
  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_regs_move_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(cfg_usb) && $stable(cfg_pci) && $stable(cfg_mem[3:0]) &&
      $stable(cfg_lr) && $stable(cfg_uv)) |-> !scl_i);

  assert_reset_values_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cfg_usb == 8'h00 && cfg_pci == 8'h00 && cfg_lr == 8'h00 &&
                       cfg_uv == 8'h07 && cfg_mem[3:0] == 4'h0));

  assert_type_bit_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mem[7] == type_det && cfg_mem[6:4] == 3'b000);

  assert_pci_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pci[7:3] == 5'b00000);
endmodule

bind i2c_cfg_regs i2c_cfg_regs_chk u_chk (.*);

// File: tb/tb_i2c_cfg_regs.sv
module tb_i2c_cfg_regs;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic strap_a0 = 1'b1, type_det = 1'b0;
  logic sda_oe;
  logic [7:0] cfg_usb, cfg_pci, cfg_mem, cfg_lr, cfg_uv;
  wire sda_line = ~(sda_oe | m_low);
  int errors = 0, checks = 0;
  bit hold = 1'b0, done = 1'b0;
  logic [7:0] mreg [0:7];

  always #5 clk = ~clk;

  i2c_cfg_regs dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a0(strap_a0), .type_det(type_det), .cfg_usb(cfg_usb), .cfg_pci(cfg_pci),
    .cfg_mem(cfg_mem), .cfg_lr(cfg_lr), .cfg_uv(cfg_uv));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [6:0] off);
    case (off)
      7'h00, 7'h03, 7'h05: return mreg[off[2:0]];
      7'h01: return mreg[1] & 8'h07;
      7'h02: return {type_det, 3'b000, mreg[2][3:0]};
      7'h04: return 8'hA1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void m_write(input logic [6:0] off, input logic [7:0] d);
    case (off)
      7'h00, 7'h01, 7'h02, 7'h03, 7'h05: mreg[off[2:0]] = d;
      default: ;
    endcase
  endfunction

  always @(negedge clk)
    if (rst_n && !hold && !done) begin
      chk("R10 cfg_usb", cfg_usb, m_read(7'h00));
      chk("R10 cfg_pci", cfg_pci, m_read(7'h01));
      chk("R10 cfg_mem", cfg_mem, m_read(7'h02));
      chk("R10 cfg_lr", cfg_lr, m_read(7'h03));
      chk("R10 cfg_uv", cfg_uv, m_read(7'h05));
    end

  task automatic qwait();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; qwait(); m_low = 1'b1; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic i2c_rstart();
    m_low = 1'b0; qwait(); scl = 1'b1; qwait(); m_low = 1'b1; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qwait(); scl = 1'b1; qwait(); m_low = 1'b0; qwait(); qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    end
    m_low = 1'b0; qwait(); scl = 1'b1; qwait(); ack = ~sda_line; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic recv_byte(output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl = 1'b1; qwait(); d[i] = sda_line; qwait(); scl = 1'b0; qwait();
    end
    qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
  endtask

  function automatic bit addr_ok(input logic [7:0] a, input bit rd);
    return a[7:1] == {6'b010111, strap_a0} && a[0] == rd;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] cmd, input logic [7:0] d);
    bit ka, kc, kd, ea, ec;
    ea = addr_ok(a, 1'b0);
    ec = ea && cmd[7];
    i2c_start();
    send_byte(a, ka);
    chk("R1 write address ack", ka, ea);
    send_byte(cmd, kc);
    chk("R4 command ack", kc, ec);
    if (ec) hold = 1'b1;
    send_byte(d, kd);
    chk("R2 data ack", kd, ec);
    if (ec) m_write(cmd[6:0], d);
    hold = 1'b0;
    i2c_stop();
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [6:0] off);
    bit ka, kc, kr;
    logic [7:0] d;
    i2c_start();
    send_byte(a & 8'hFE, ka);
    chk("R1 read setup address ack", ka, addr_ok(a & 8'hFE, 1'b0));
    send_byte({1'b1, off}, kc);
    chk("R3 read command ack", kc, ka);
    i2c_rstart();
    send_byte(a | 8'h01, kr);
    chk("R3 read address ack", kr, addr_ok(a | 8'h01, 1'b1));
    recv_byte(d);
    if (kr) chk(tag, d, m_read(off));
    else chk("R1 no drive after mismatch", d, 8'hFF);
    chk("R3 release after byte", sda_oe, 0);
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    mreg[5] = 8'h07;
    repeat (5) @(negedge clk);
    chk("R5 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset usb", cfg_usb, 8'h00);
    chk("R5 reset pci", cfg_pci, 8'h00);
    chk("R5 reset lr", cfg_lr, 8'h00);
    chk("R5 reset uv", cfg_uv, 8'h07);
    rd_chk("R5 read uv after reset", 8'h5E, 7'h05);
    wr(8'h5E, 8'h80, 8'h5A);
    rd_chk("R2 R3 readback usb", 8'h5E, 7'h00);
    wr(8'h5E, 8'h81, 8'hFF);
    rd_chk("R8 pci masked", 8'h5E, 7'h01);
    wr(8'h5E, 8'h82, 8'hFF);
    rd_chk("R7 mem with detect low", 8'h5E, 7'h02);
    type_det = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 live detect bit", cfg_mem[7], 1);
    rd_chk("R7 mem with detect high", 8'h5E, 7'h02);
    wr(8'h5E, 8'h82, 8'h05);
    rd_chk("R7 mem low nibble", 8'h5E, 7'h02);
    wr(8'h5E, 8'h84, 8'h55);
    rd_chk("R6 chip id", 8'h5E, 7'h04);
    wr(8'h5E, 8'h86, 8'hFF);
    rd_chk("R6 version id", 8'h5E, 7'h06);
    wr(8'h5E, 8'hC0, 8'hFF);
    rd_chk("R9 unimplemented offset", 8'h5E, 7'h40);
    rd_chk("R9 unimplemented offset 07", 8'h5E, 7'h07);
    wr(8'h5C, 8'h83, 8'h77);
    rd_chk("R1 mismatch read", 8'h5C, 7'h03);
    strap_a0 = 1'b0;
    wr(8'h5C, 8'h83, 8'h3C);
    rd_chk("R2 lr via strap low", 8'h5C, 7'h03);
    wr(8'h5E, 8'h83, 8'h99);
    wr(8'h5C, 8'h05, 8'h12);
    rd_chk("R4 uv unchanged", 8'h5C, 7'h05);
    wr(8'h5C, 8'h85, 8'h12);
    rd_chk("R2 uv written", 8'h5C, 7'h05);
    wr(8'h5C, 8'h80, 8'hA5);
    rd_chk("R3 usb pattern", 8'h5C, 7'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule